// File: doc/BRIEF.md
# Autonomous Wake-Up Sequencer

This block keeps a sleeping radio on a periodic listen schedule without the host being involved. A 32.768 kHz tick, taken from either an RC oscillator or a crystal oscillator, is divided first by a power-of-two prescaler and then by a 16-bit reload count. The result is a hardware wake period. A second 16-bit counter counts those periods. When that counter reaches its programmed value, the block turns the receiver on for a dwell window that lasts a programmed number of ticks.

During the dwell, receive-event pulses from the packet detector are filtered through a mask. The events are preamble found, sync word found, CRC good and address match. If any masked event arrives, the block raises a sticky host interrupt and leaves the radio awake. If no masked event arrives before the window closes, the radio returns to sleep quietly and a new period is counted from zero.

The host can force the radio awake at any time and can later send it back to sleep. All pins are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `wake_sequencer`

## Requirements
- R1: After reset, radio_on, dwell_active, host_awake, irq and irq_cause are all 0.
- R2: Only the tick input chosen by clk_sel advances any timing (clk_sel=0 selects rc_tick, clk_sel=1 selects xo_tick). Pulses on the other tick input have no effect.
- R3: After entering sleep with cleared counters, dwell_active and radio_on rise after the clock edge that samples tick number (wake_count+1)*(period_reload+1)*2^prescale_exp.
- R4: A dwell with no masked event lasts dwell_len+1 ticks. The radio then sleeps with irq unchanged, and the next dwell needs a full period counted from zero.
- R5: During a dwell, an rx_evt bit whose evt_mask bit is set causes the following on the next edge: irq=1, irq_cause ORs in the masked bits, host_awake=1, dwell_active=0 and radio_on stays 1. The bit positions are 0 preamble, 1 sync word, 2 CRC good and 3 address match.
- R6: Events with a clear mask bit, and any events outside a dwell, change neither irq, irq_cause nor the state.
- R7: A masked event sampled on the same edge as the final dwell tick wins, and the radio stays awake with irq raised.
- R8: irq stays high until irq_ack is pulsed, which clears irq and irq_cause. If a new masked event arrives on the same edge as irq_ack, irq stays 1 and irq_cause holds only the new bits.
- R9: host_wake moves any state to awake on the next edge without raising irq and clears the period counters. The radio then stays awake through any ticks until host_sleep, after which a full period is counted afresh.
- R10: With enable low the block leaves sleep or dwell for idle, where the radio is off and ticks are ignored. Raising enable starts sleep with cleared counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows autonomous wake cycles |
| clk_sel | input | 1 | Tick source: 0 RC, 1 crystal |
| rc_tick | input | 1 | One-cycle pulse per RC oscillator period |
| xo_tick | input | 1 | One-cycle pulse per crystal oscillator period |
| prescale_exp | input | 3 | Prescaler exponent, divide by 2^value |
| period_reload | input | 16 | Hardware period is value+1 prescaled ticks |
| wake_count | input | 16 | Dwell every value+1 hardware periods |
| dwell_len | input | 8 | Dwell lasts value+1 ticks |
| evt_mask | input | 4 | Selects events that wake the host |
| rx_evt | input | 4 | Receive-event pulses from the packet detector |
| host_wake | input | 1 | Forces the radio awake |
| host_sleep | input | 1 | Returns an awake radio to sleep |
| irq_ack | input | 1 | Write-one-to-clear for irq and irq_cause |
| radio_on | output | 1 | Receiver powered (dwell or awake) |
| dwell_active | output | 1 | Autonomous dwell window open |
| host_awake | output | 1 | Radio held awake for the host |
| irq | output | 1 | Sticky host interrupt |
| irq_cause | output | 4 | Masked events that raised irq |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a masked receive event arriving on the tick that closes the dwell. The bench provokes it by driving the event and the last dwell tick in the same cycle, and it judges the result as correct only if the radio is left awake with irq set. The second pair is an acknowledge arriving as a new event sets the interrupt. The bench leaves an earlier interrupt pending through a second dwell and pulses irq_ack together with a different masked event. It expects irq to stay high and irq_cause to carry only the new bits.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_SLEEP = 2'd1,
    WS_DWELL = 2'd2,
    WS_AWAKE = 2'd3
  } ws_state_e;

  localparam int EVT_N      = 4;
  localparam int EVT_PREAMB = 0;
  localparam int EVT_SYNC   = 1;
  localparam int EVT_CRC    = 2;
  localparam int EVT_ADDR   = 3;
endpackage

// File: rtl/wake_stage_cnt.sv
module wake_stage_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = inc && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (inc)   cnt <= done ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/wake_seq_fsm.sv
module wake_seq_fsm
  import wake_seq_pkg::*;
#(
  parameter int EV_W = EVT_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            host_wake,
  input  logic            host_sleep,
  input  logic            period_done,
  input  logic            dwell_done,
  input  logic [EV_W-1:0] match_vec,
  input  logic            irq_ack,
  output ws_state_e       state,
  output logic            irq,
  output logic [EV_W-1:0] irq_cause
);
  ws_state_e nxt;
  logic      hit;
  logic      irq_set;

  assign hit     = |match_vec;
  assign irq_set = (state == WS_DWELL) && hit;

  always_comb begin
    nxt = state;
    if (host_wake) begin
      nxt = WS_AWAKE;
    end else begin
      case (state)
        WS_IDLE:  if (enable) nxt = WS_SLEEP;
        WS_SLEEP: begin
          if (!enable)          nxt = WS_IDLE;
          else if (period_done) nxt = WS_DWELL;
        end
        WS_DWELL: begin
          if (hit)              nxt = WS_AWAKE;
          else if (!enable)     nxt = WS_IDLE;
          else if (dwell_done)  nxt = WS_SLEEP;
        end
        WS_AWAKE: if (host_sleep) nxt = enable ? WS_SLEEP : WS_IDLE;
        default:  nxt = WS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= WS_IDLE;
      irq       <= 1'b0;
      irq_cause <= '0;
    end else begin
      state <= nxt;
      if (irq_set) begin
        irq       <= 1'b1;
        irq_cause <= irq_ack ? match_vec : (irq_cause | match_vec);
      end else if (irq_ack) begin
        irq       <= 1'b0;
        irq_cause <= '0;
      end
    end
  end
endmodule

// File: rtl/wake_sequencer.sv
module wake_sequencer
  import wake_seq_pkg::*;
#(
  parameter int EXP_W    = 3,
  parameter int RELOAD_W = 16,
  parameter int COUNT_W  = 16,
  parameter int DWELL_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                clk_sel,
  input  logic                rc_tick,
  input  logic                xo_tick,
  input  logic [EXP_W-1:0]    prescale_exp,
  input  logic [RELOAD_W-1:0] period_reload,
  input  logic [COUNT_W-1:0]  wake_count,
  input  logic [DWELL_W-1:0]  dwell_len,
  input  logic [EVT_N-1:0]    evt_mask,
  input  logic [EVT_N-1:0]    rx_evt,
  input  logic                host_wake,
  input  logic                host_sleep,
  input  logic                irq_ack,
  output logic                radio_on,
  output logic                dwell_active,
  output logic                host_awake,
  output logic                irq,
  output logic [EVT_N-1:0]    irq_cause
);
  localparam int PRE_W = (1 << EXP_W) - 1;

  ws_state_e            state;
  logic                 tick;
  logic                 in_sleep;
  logic                 in_dwell;
  logic [PRE_W-1:0]     pre_lim;
  logic                 pre_done;
  logic                 hw_done;
  logic                 period_done;
  logic                 dwell_done;
  logic [EVT_N-1:0]     match_vec;

  assign tick      = clk_sel ? xo_tick : rc_tick;
  assign in_sleep  = (state == WS_SLEEP);
  assign in_dwell  = (state == WS_DWELL);
  assign match_vec = rx_evt & evt_mask;

  // Prescaler limit is 2^exp - 1: the low exp bits set.
  always_comb begin
    for (int i = 0; i < PRE_W; i++) pre_lim[i] = (i < int'(prescale_exp));
  end

  wake_stage_cnt #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(!in_sleep), .inc(tick && in_sleep),
    .limit(pre_lim), .done(pre_done)
  );

  wake_stage_cnt #(.W(RELOAD_W)) u_hw (
    .clk(clk), .rst_n(rst_n), .clr(!in_sleep), .inc(pre_done),
    .limit(period_reload), .done(hw_done)
  );

  wake_stage_cnt #(.W(COUNT_W)) u_fw (
    .clk(clk), .rst_n(rst_n), .clr(!in_sleep), .inc(hw_done),
    .limit(wake_count), .done(period_done)
  );

  wake_stage_cnt #(.W(DWELL_W)) u_dwell (
    .clk(clk), .rst_n(rst_n), .clr(!in_dwell), .inc(tick && in_dwell),
    .limit(dwell_len), .done(dwell_done)
  );

  wake_seq_fsm #(.EV_W(EVT_N)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .host_wake(host_wake),
    .host_sleep(host_sleep), .period_done(period_done),
    .dwell_done(dwell_done), .match_vec(match_vec), .irq_ack(irq_ack),
    .state(state), .irq(irq), .irq_cause(irq_cause)
  );

  assign dwell_active = in_dwell;
  assign host_awake   = (state == WS_AWAKE);
  assign radio_on     = in_dwell || (state == WS_AWAKE);
endmodule

// File: rtl/wake_sequencer_chk.sv
module wake_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic clk_sel,
  input logic rc_tick,
  input logic xo_tick,
  input logic host_wake,
  input logic irq_ack,
  input logic dwell_active,
  input logic host_awake,
  input logic irq
);
  logic tk;
  assign tk = clk_sel ? xo_tick : rc_tick;

  AST_DWELL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dwell_active) |-> $past(tk)); // R3
  AST_DWELL_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dwell_active) && !host_awake) |-> ($past(tk) || !$past(enable))); // R4
  AST_IRQ_FROM_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(dwell_active) && host_awake)); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !dwell_active) |=> !irq); // R8
  AST_HOST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    host_wake |=> (host_awake && !dwell_active)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !host_awake && !dwell_active) |=> !dwell_active); // R10
endmodule

bind wake_sequencer wake_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .clk_sel(clk_sel),
  .rc_tick(rc_tick), .xo_tick(xo_tick), .host_wake(host_wake),
  .irq_ack(irq_ack), .dwell_active(dwell_active),
  .host_awake(host_awake), .irq(irq)
);

// File: tb/wake_sequencer_test.sv
module wake_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        clk_sel = 1'b0;
  logic        rc_tick = 1'b0;
  logic        xo_tick = 1'b0;
  logic [2:0]  prescale_exp = '0;
  logic [15:0] period_reload = '0;
  logic [15:0] wake_count = '0;
  logic [7:0]  dwell_len = '0;
  logic [3:0]  evt_mask = '0;
  logic [3:0]  rx_evt = '0;
  logic        host_wake = 1'b0;
  logic        host_sleep = 1'b0;
  logic        irq_ack = 1'b0;
  logic        radio_on, dwell_active, host_awake, irq;
  logic [3:0]  irq_cause;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wake_sequencer uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clk_sel(clk_sel),
    .rc_tick(rc_tick), .xo_tick(xo_tick), .prescale_exp(prescale_exp),
    .period_reload(period_reload), .wake_count(wake_count),
    .dwell_len(dwell_len), .evt_mask(evt_mask), .rx_evt(rx_evt),
    .host_wake(host_wake), .host_sleep(host_sleep), .irq_ack(irq_ack),
    .radio_on(radio_on), .dwell_active(dwell_active),
    .host_awake(host_awake), .irq(irq), .irq_cause(irq_cause)
  );

  function automatic int period_ticks(int e, int r, int t);
    return (t + 1) * (r + 1) * (1 << e);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One-cycle pulse on a chosen tick line, n times, with idle cycles between.
  task automatic pulse_src(bit which, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rc_tick = !which;
      xo_tick = which;
      @(negedge clk);
      rc_tick = 1'b0;
      xo_tick = 1'b0;
    end
  endtask

  task automatic ticks(int n);
    pulse_src(clk_sel, n);
  endtask

  task automatic evt_pulse(logic [3:0] e, bit with_tick, bit with_ack);
    @(negedge clk);
    rx_evt  = e;
    irq_ack = with_ack;
    if (with_tick) begin
      rc_tick = !clk_sel;
      xo_tick = clk_sel;
    end
    @(negedge clk);
    rx_evt  = '0;
    irq_ack = 1'b0;
    rc_tick = 1'b0;
    xo_tick = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic configure(int e, int r, int t, int d, logic [3:0] m, bit s);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    prescale_exp  = 3'(e);
    period_reload = 16'(r);
    wake_count    = 16'(t);
    dwell_len     = 8'(d);
    evt_mask      = m;
    clk_sel       = s;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int p;
    logic [3:0] e;
    process_main();
  end

  task automatic process_main();
    int p;
    logic [3:0] e;
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 radio_on", radio_on, 0);
    chk("R1 dwell_active", dwell_active, 0);
    chk("R1 host_awake", host_awake, 0);
    chk("R1 irq", irq, 0);
    chk("R1 irq_cause", irq_cause, 0);

    // Directed: period 4 ticks, dwell 3 ticks, mask preamble+CRC.
    configure(1, 1, 0, 2, 4'b0101, 1'b0);
    p = period_ticks(1, 1, 0);
    pulse_src(1'b1, 9);
    chk("R2 unselected source ignored", dwell_active, 0);
    ticks(p - 1);
    chk("R3 no dwell before period", dwell_active, 0);
    ticks(1);
    chk("R3 dwell at period end", dwell_active, 1);
    chk("R3 radio on in dwell", radio_on, 1);
    evt_pulse(4'b1010, 1'b0, 1'b0);
    chk("R6 unmasked event ignored irq", irq, 0);
    chk("R6 unmasked event keeps dwell", dwell_active, 1);
    ticks(2);
    chk("R4 dwell still open", dwell_active, 1);
    ticks(1);
    chk("R4 dwell closed", radio_on, 0);
    chk("R4 no irq after quiet dwell", irq, 0);
    evt_pulse(4'b0101, 1'b0, 1'b0);
    chk("R6 event while asleep ignored", irq, 0);

    // Match on the final dwell tick.
    ticks(p);
    chk("R3 second dwell", dwell_active, 1);
    ticks(2);
    evt_pulse(4'b0001, 1'b1, 1'b0);
    chk("R7 match wins over dwell end", host_awake, 1);
    chk("R7 irq raised", irq, 1);
    chk("R5 cause preamble", irq_cause, 4'b0001);
    chk("R5 radio stays on", radio_on, 1);

    // Leave irq pending, sleep, new match together with ack.
    pulse(host_sleep);
    chk("R8 irq held across sleep", irq, 1);
    chk("R9 host_sleep returns to sleep", radio_on, 0);
    ticks(p);
    chk("R3 third dwell", dwell_active, 1);
    evt_pulse(4'b0100, 1'b0, 1'b1);
    chk("R8 set wins over ack", irq, 1);
    chk("R8 cause holds new bits only", irq_cause, 4'b0100);
    pulse(irq_ack);
    chk("R8 ack clears irq", irq, 0);
    chk("R8 ack clears cause", irq_cause, 0);
    pulse(host_sleep);

    // Host wake mid-count restarts the period.
    ticks(p - 1);
    pulse(host_wake);
    chk("R9 host wake -> awake", host_awake, 1);
    chk("R9 host wake no irq", irq, 0);
    ticks(10);
    chk("R9 stays awake through ticks", host_awake, 1);
    pulse(host_sleep);
    ticks(p - 1);
    chk("R9 period restarted", dwell_active, 0);
    ticks(1);
    chk("R9 dwell after fresh period", dwell_active, 1);
    pulse(host_wake);
    chk("R9 host wake during dwell", host_awake, 1);
    chk("R9 dwell closed by host wake", dwell_active, 0);
    ticks(5);
    chk("R9 radio kept on", radio_on, 1);
    pulse(host_sleep);

    // Enable low -> idle.
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    ticks(3 * p);
    chk("R10 idle ignores ticks", radio_on, 0);
    evt_pulse(4'b1111, 1'b0, 1'b0);
    chk("R10 idle ignores events", irq, 0);
    enable = 1'b1;
    @(negedge clk);
    ticks(p);
    chk("R10 dwell after re-enable", dwell_active, 1);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R10 disable closes dwell", radio_on, 0);

    // Random configurations.
    for (int it = 0; it < 24; it++) begin
      int ex = $urandom_range(0, 2);
      int rl = $urandom_range(0, 4);
      int tg = $urandom_range(0, 3);
      int dl = $urandom_range(0, 3);
      logic [3:0] mk = 4'($urandom_range(1, 15));
      bit sl = 1'($urandom_range(0, 1));
      int mode = $urandom_range(0, 2);
      configure(ex, rl, tg, dl, mk, sl);
      p = period_ticks(ex, rl, tg);
      pulse_src(!sl, 3);
      ticks(p - 1);
      chk("R3 random no early dwell", dwell_active, 0);
      ticks(1);
      chk("R3 random dwell start", dwell_active, 1);
      if (mode == 1) begin
        e = 4'($urandom_range(0, 15)) | (mk & (~mk + 4'd1));
        evt_pulse(e, 1'b0, 1'b0);
        chk("R5 random irq", irq, 1);
        chk("R5 random cause", irq_cause, e & mk);
        chk("R5 random awake", host_awake, 1);
        pulse(irq_ack);
        chk("R8 random ack", irq, 0);
        pulse(host_sleep);
        chk("R9 random sleep", radio_on, 0);
      end else begin
        if (mode == 2 && (~mk & 4'hf) != 0) begin
          evt_pulse(~mk & 4'hf, 1'b0, 1'b0);
          chk("R6 random unmasked", irq, 0);
        end
        ticks(dl + 1);
        chk("R4 random dwell end", radio_on, 0);
        chk("R4 random no irq", irq, 0);
        ticks(p);
        chk("R4 random next dwell", dwell_active, 1);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule